// File: doc/BRIEF.md
# Processor Watchdog Reset Supervisor

This block watches a heartbeat line that a processor toggles from software and drives an active-low reset whenever the heartbeat stops. Any change of level on the heartbeat line, rising or falling, restarts a timeout counter. If the counter reaches the timeout without seeing a change, reset asserts and is held for a fixed stretch period before it is released. A power-good input that drops also forces reset, and the stretch period then runs only after the supply is good again.

A configuration input marks the heartbeat line as undriven. In that mode the line's level is ignored, and the counter clears itself at seven eighths of the timeout, so no watchdog reset ever occurs. The timeout and stretch lengths are parameters counted in clock cycles. The clock period must not be longer than the shortest heartbeat pulse that has to be seen. The heartbeat passes through a two-stage synchronizer before its edges are detected.

Top module: `hb_supervisor`

## Requirements
- R1: While `rstN` is low, `resetN` is 0. After `rstN` rises, `resetN` stays 0 for STRETCH_CYC rising clock edges and reads 1 from the STRETCH_CYC-th edge on.
- R2: Once reset asserts with `supplyOk` high, `resetN` stays 0 for exactly STRETCH_CYC clock edges and then returns to 1.
- R3: With no heartbeat change and `hbFloat` low, `resetN` falls on the TIMEOUT_CYC-th clock edge after the edge on which it rose.
- R4: A rising or a falling change of `hbIn` restarts the timeout. A change applied before clock edge n clears the counter at edge n+2 (two synchronizer stages plus the edge register). The next expiry then falls TIMEOUT_CYC edges after that clear.
- R5: The timeout counter is held at zero while reset is asserted and starts counting on the edge where `resetN` rises.
- R6: While `hbFloat` is 1, changes on `hbIn` are ignored and the counter clears itself once it reaches (TIMEOUT_CYC*7)/8, so `resetN` never falls for lack of a heartbeat.
- R7: `supplyOk` low asserts `resetN` (0) on the next clock edge and holds it there. The STRETCH_CYC stretch counts from the first edge at which `supplyOk` is high again.
- R8: A heartbeat clear that lands on the same edge as the timeout expiry wins: reset does not assert, and the counter restarts from zero.
- R9: An undervoltage and a timeout expiry on the same edge produce a single reset, whose stretch is measured from supply recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| supplyOk | input | 1 | Supply above threshold when 1 |
| hbIn | input | 1 | Processor heartbeat line, asynchronous |
| hbFloat | input | 1 | 1 marks the heartbeat line as undriven (disabled mode) |
| resetN | output | 1 | Supervisor reset to the processor, active low |

## Verification
Two pairs of functions can meet on one clock edge. The first is a heartbeat clear together with the timeout expiry. The bench changes `hbIn` three cycles before the expiry edge, so that the synchronized edge arrives exactly on that edge, and then expects `resetN` to stay high and the next expiry a full timeout later. The second is an undervoltage together with the expiry. Here `supplyOk` is dropped one cycle before the expiry edge, and the bench requires a single low pulse whose release comes STRETCH_CYC edges after `supplyOk` returns.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic holdWdog;    // keep the timeout counter at zero
    logic clrStretch;  // restart the stretch counter
    logic incStretch;  // advance the stretch counter
  } supStrobe_t;

endpackage

// File: rtl/hb_sup_datapath.sv
module hb_sup_datapath
  import hb_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32_000_000,
  parameter int STRETCH_CYC = 5_600_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hbIn,
  input  logic       hbFloat,
  input  supStrobe_t strobes,
  output logic       wdExpire,
  output logic       stretchDone
);

  localparam int WD_W = $clog2(TIMEOUT_CYC);
  localparam int ST_W = $clog2(STRETCH_CYC);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_CYC - 1);
  localparam logic [WD_W-1:0] FLOAT_CLR = WD_W'((TIMEOUT_CYC * 7) / 8);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STRETCH_CYC - 1);

  // Heartbeat synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= hbIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= 1'b0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  logic hbSynced;
  logic hbPrev;
  assign hbSynced = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hbPrev <= 1'b0;
    else       hbPrev <= hbSynced;
  end

  // Either polarity of change is a heartbeat
  logic hbToggle;
  logic useToggle;
  logic floatClr;
  logic [WD_W-1:0] wdCount;

  assign hbToggle  = hbSynced ^ hbPrev;
  assign useToggle = hbToggle && !hbFloat;
  assign floatClr  = hbFloat && (wdCount >= FLOAT_CLR);
  assign wdExpire  = !strobes.holdWdog && !useToggle && !floatClr && (wdCount == WD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCount <= '0;
    end else if (strobes.holdWdog || useToggle || floatClr || wdExpire) begin
      wdCount <= '0;
    end else begin
      wdCount <= wdCount + 1'b1;
    end
  end

  // Reset stretch counter
  logic [ST_W-1:0] stCount;

  assign stretchDone = (stCount == ST_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stCount <= '0;
    end else if (strobes.clrStretch) begin
      stCount <= '0;
    end else if (strobes.incStretch) begin
      stCount <= stCount + 1'b1;
    end
  end

  // R5: counter frozen while reset is held
  assert_frozen_in_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdWdog |=> (wdCount == '0));

  // R4, R8: a seen heartbeat restarts the count even at the expiry point
  assert_toggle_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    useToggle |=> (wdCount == '0));

  // R6: in disabled mode the count never passes the internal clear point
  assert_float_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hbFloat) && hbFloat) |-> (wdCount <= FLOAT_CLR));

  // R2: stretch counter never runs past its last value
  assert_stretch_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    stretchDone |=> (stCount <= ST_LAST));

endmodule

// File: rtl/hb_sup_control.sv
module hb_sup_control
  import hb_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       wdExpire,
  input  logic       stretchDone,
  output supStrobe_t strobes,
  output logic       resetN
);

  supState_e state;
  supState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_HOLD: if (supplyOk && stretchDone) stateNext = ST_RUN;
      ST_RUN:  if (!supplyOk || wdExpire)   stateNext = ST_HOLD;
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.holdWdog   = (state == ST_HOLD);
    strobes.clrStretch = (state == ST_RUN) || !supplyOk;
    strobes.incStretch = (state == ST_HOLD) && supplyOk && !stretchDone;
  end

  assign resetN = (state == ST_RUN);

  // R7: undervoltage asserts reset on the next edge
  assert_uv_asserts_R7: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !resetN);

  // R3: an expiry while running asserts reset
  assert_expire_asserts_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resetN && wdExpire) |=> !resetN);

  // R2: release only after a completed stretch with a good supply
  assert_release_after_stretch_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> ($past(stretchDone) && $past(supplyOk)));

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32_000_000,
  parameter int STRETCH_CYC = 5_600_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic hbIn,
  input  logic hbFloat,
  output logic resetN
);

  supStrobe_t strobes;
  logic       wdExpire;
  logic       stretchDone;

  hb_sup_datapath #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .STRETCH_CYC(STRETCH_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .hbIn       (hbIn),
    .hbFloat    (hbFloat),
    .strobes    (strobes),
    .wdExpire   (wdExpire),
    .stretchDone(stretchDone)
  );

  hb_sup_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .wdExpire   (wdExpire),
    .stretchDone(stretchDone),
    .strobes    (strobes),
    .resetN     (resetN)
  );

endmodule

// File: tb/test_hb_supervisor.sv
module test_hb_supervisor;

  localparam int T = 32;
  localparam int S = 12;

  // Scenario anchors derived from the requirements
  localparam int E2 = 2 * S + T;          // run after first timeout pulse
  localparam int L  = E2 + 70;            // last keep-alive toggle
  localparam int E3 = L + 3 + T + S;
  localparam int E4 = E3 + 2 * T + S;
  localparam int F  = E4 + 3 * T;         // float mode ends
  localparam int E5 = F + 3 + T + S;
  localparam int U  = E5 + 25;            // supply returns
  localparam int E6 = U + S;
  localparam int LAST = E6 + T + 3 + S;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b1;
  logic hbIn = 1'b0;
  logic hbFloat = 1'b0;
  logic resetN;

  always #2 clk = ~clk;   // 4 ns period

  hb_supervisor #(.TIMEOUT_CYC(T), .STRETCH_CYC(S), .SYNC_STAGES(2)) i_hb_supervisor (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .hbIn(hbIn), .hbFloat(hbFloat), .resetN(resetN)
  );

  typedef struct {
    int    cyc;
    logic  val;
    string req;
  } sbItem_t;

  sbItem_t sbQ[$];
  sbItem_t cur;
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic expectAt(input int c, input logic v, input string r);
    sbItem_t it;
    it.cyc = c; it.val = v; it.req = r;
    sbQ.push_back(it);
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: pop and compare at the matching cycle
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].cyc == cyc) begin
      cur = sbQ.pop_front();
      nChecks++;
      if (resetN !== cur.val) begin
        nFails++;
        $display("FAIL %s cyc %0d resetN=%b expected %b", cur.req, cyc, resetN, cur.val);
      end
    end
  end

  // Driver: expectations
  initial begin
    expectAt(0, 1'b0, "R1");
    expectAt(S - 1, 1'b0, "R1");
    expectAt(S, 1'b1, "R1");
    expectAt(S + T - 1, 1'b1, "R5");
    expectAt(S + T, 1'b0, "R3");
    expectAt(2 * S + T - 1, 1'b0, "R2");
    expectAt(E2, 1'b1, "R2");
    expectAt(E2 + 10 + T + 5, 1'b1, "R4");
    expectAt(L + 3 + T - 1, 1'b1, "R4");
    expectAt(L + 3 + T, 1'b0, "R4");
    expectAt(E3 + T, 1'b1, "R8");
    expectAt(E3 + 2 * T - 1, 1'b1, "R8");
    expectAt(E3 + 2 * T, 1'b0, "R8");
    expectAt(F, 1'b1, "R6");
    expectAt(F + 3 + T - 1, 1'b1, "R6");
    expectAt(F + 3 + T, 1'b0, "R6");
    expectAt(E5 + 5, 1'b1, "R7");
    expectAt(E5 + 6, 1'b0, "R7");
    expectAt(U - 1, 1'b0, "R7");
    expectAt(U + S - 1, 1'b0, "R7");
    expectAt(U + S, 1'b1, "R7");
    expectAt(E6 + T - 1, 1'b1, "R9");
    expectAt(E6 + T, 1'b0, "R9");
    expectAt(E6 + T + 3 + S - 1, 1'b0, "R9");
    expectAt(E6 + T + 3 + S, 1'b1, "R9");
  end

  // Driver: stimulus
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R4: alternating polarity keep-alive toggles
    for (int k = 0; k < 4; k++) begin
      waitCyc(E2 + 10 + 20 * k);
      hbIn = ~hbIn;
    end
    // R8: clear lands on the expiry edge
    waitCyc(E3 + T - 3);
    hbIn = ~hbIn;
    // R6: disabled mode over three timeouts, then a fresh toggle
    waitCyc(E4);
    hbFloat = 1'b1;
    waitCyc(E4 + T + 4);
    hbIn = ~hbIn;
    waitCyc(F);
    hbFloat = 1'b0;
    hbIn = ~hbIn;
    // R7: undervoltage
    waitCyc(E5 + 5);
    supplyOk = 1'b0;
    waitCyc(U);
    supplyOk = 1'b1;
    // R9: undervoltage on the expiry edge
    waitCyc(E6 + T - 1);
    supplyOk = 1'b0;
    waitCyc(E6 + T + 3);
    supplyOk = 1'b1;
    waitCyc(LAST + 2);
    if (sbQ.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard %0d items left, expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog cyc %0d expected end by %0d", cyc, LAST + 2);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule